// File: doc/BRIEF.md
# UART Oversample Tick Generator

This block derives the 16x oversampling tick for a UART receiver and transmitter from the peripheral clock. It works in two stages. A small prescaler divides the clock by 2 or by 3, as chosen by a select bit in the control word. A down-counter then divides the prescaler output by the reload value plus one. A baud rate is set by programming the reload register with (f_clk / (16 × baud)) / 2 − 1 and leaving the prescaler at divide-by-2.

A run bit in the control word starts and stops the generator. While run is low, both stages are held cleared and no tick is produced. The reload register accepts writes only while the generator is stopped. Software therefore clears run, writes the reload value and sets run again. The control word also holds a fractional-divide enable bit, which this block keeps disabled: the bit has no effect. Bus decode and the serial shifters sit outside the block.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset, tick_o and running_o are 0, the held reload value is 0 and the prescaler divides by 2.
- R2: While running, ticks repeat every P × (R + 1) clock cycles, where R is the held reload value and P is 2 when control bit 8 is 0 and 3 when it is 1.
- R3: The first tick is visible P × (R + 1) − 1 clock edges after the edge that captures run = 1 (control bit 15).
- R4: tick_o is high for exactly one clock cycle per tick.
- R5: running_o follows control bit 15 from the cycle after the control write. While running_o is 0, tick_o stays 0 and both stages are held cleared.
- R6: A reload write while running_o is 1 is ignored. The period does not change, and the next restart still uses the previously held value.
- R7: The reload register is 13 bits wide and takes writes while stopped. A reload write in the same cycle as the control write that sets run is taken and used for the first tick.
- R8: Control bit 9 (fractional-divide enable) has no effect on tick timing.
- R9: With P = 2 and reload (f_clk / (16 × baud)) / 2 − 1, the tick period equals f_clk / (16 × baud) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control word write strobe |
| ctrl_wdata_i | input | 16 | Control word: bit 15 run, bit 9 fractional enable (ignored), bit 8 prescaler select |
| reload_we_i | input | 1 | Reload register write strobe |
| reload_wdata_i | input | 13 | Reload value |
| tick_o | output | 1 | Single-cycle oversample tick |
| running_o | output | 1 | Generator running |

## Verification
The assertions assume that the write strobes are clean and synchronous, and that the prescaler select changes only through full control-word writes. They also take reset as the only way to reach a known state. The bench drives every write as one-cycle strobes at the falling edge. It changes the reload value only after an explicit stop, except in the cases where it means to test the ignore path. Random reload values and prescaler choices are drawn from a seeded generator. Directed cases cover a reload of 0, the 13-bit maximum, a write in the same cycle as run, and a realistic baud setting.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;
  localparam int unsigned CTRL_W     = 16;
  localparam int unsigned RELOAD_W   = 13;
  localparam int unsigned BIT_PRESEL = 8;
  localparam int unsigned BIT_FRAC   = 9;
  localparam int unsigned BIT_RUN    = 15;
  localparam int unsigned PRE_W      = 2;

  typedef struct packed {
    logic run;
    logic presel;
  } ctrl_t;

  // last prescaler count: 1 for /2, 2 for /3
  function automatic logic [PRE_W-1:0] pre_last(input logic presel);
    return presel ? PRE_W'(2) : PRE_W'(1);
  endfunction
endpackage

// File: rtl/baud_gen_regs.sv
module baud_gen_regs
  import baud_gen_pkg::*;
#(
  parameter int unsigned CW = CTRL_W,
  parameter int unsigned RW = RELOAD_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ctrl_we_i,
  input  logic [CW-1:0] ctrl_wdata_i,
  input  logic          reload_we_i,
  input  logic [RW-1:0] reload_wdata_i,
  output ctrl_t         ctrl_o,
  output logic [RW-1:0] reload_o,
  output logic [RW-1:0] reload_nxt_o
);
  ctrl_t         ctrl_q;
  logic [RW-1:0] reload_q;
  logic          reload_ok;
  logic          unused_bits;

  assign reload_ok    = reload_we_i & ~ctrl_q.run;
  assign reload_nxt_o = reload_ok ? reload_wdata_i : reload_q;
  // fractional enable and spare bits are accepted but kept inert
  assign unused_bits  = ^{ctrl_wdata_i[BIT_FRAC], ctrl_wdata_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      reload_q <= '0;
    end else begin
      if (ctrl_we_i) begin
        ctrl_q.run    <= ctrl_wdata_i[BIT_RUN];
        ctrl_q.presel <= ctrl_wdata_i[BIT_PRESEL];
      end
      reload_q <= reload_nxt_o;
    end
  end

  assign ctrl_o   = ctrl_q;
  assign reload_o = reload_q;
endmodule

// File: rtl/baud_gen_prescale.sv
module baud_gen_prescale
  import baud_gen_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             presel_i,
  output logic             pre_tick_o,
  output logic [PRE_W-1:0] cnt_o
);
  logic [PRE_W-1:0] cnt_q;
  logic             wrap;

  // >= keeps the wrap safe if the select drops while the count sits at 2
  assign wrap       = cnt_q >= pre_last(presel_i);
  assign pre_tick_o = run_i & wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (wrap)   cnt_q <= '0;
    else             cnt_q <= cnt_q + PRE_W'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/baud_gen_reload_cnt.sv
module baud_gen_reload_cnt #(
  parameter int unsigned RW = 13
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          pre_tick_i,
  input  logic [RW-1:0] load_val_i,
  output logic          zero_o,
  output logic [RW-1:0] cnt_o
);
  logic [RW-1:0] cnt_q;

  assign zero_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (!run_i)     cnt_q <= load_val_i;
    else if (pre_tick_i) cnt_q <= zero_o ? load_val_i : cnt_q - RW'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_gen_pkg::*;
#(
  parameter int unsigned CW = CTRL_W,
  parameter int unsigned RW = RELOAD_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ctrl_we_i,
  input  logic [CW-1:0] ctrl_wdata_i,
  input  logic          reload_we_i,
  input  logic [RW-1:0] reload_wdata_i,
  output logic          tick_o,
  output logic          running_o
);
  ctrl_t            ctrl;
  logic [RW-1:0]    reload_q;
  logic [RW-1:0]    reload_nxt;
  logic             pre_tick;
  logic [PRE_W-1:0] pre_cnt;
  logic             cnt_zero;
  logic [RW-1:0]    cnt_val;

  baud_gen_regs #(.CW(CW), .RW(RW)) u_regs (
    .clk_i, .rst_ni, .ctrl_we_i, .ctrl_wdata_i, .reload_we_i, .reload_wdata_i,
    .ctrl_o(ctrl), .reload_o(reload_q), .reload_nxt_o(reload_nxt)
  );

  baud_gen_prescale u_pre (
    .clk_i, .rst_ni, .run_i(ctrl.run), .presel_i(ctrl.presel),
    .pre_tick_o(pre_tick), .cnt_o(pre_cnt)
  );

  baud_gen_reload_cnt #(.RW(RW)) u_cnt (
    .clk_i, .rst_ni, .run_i(ctrl.run), .pre_tick_i(pre_tick),
    .load_val_i(reload_nxt), .zero_o(cnt_zero), .cnt_o(cnt_val)
  );

  assign tick_o    = pre_tick & cnt_zero;
  assign running_o = ctrl.run;
endmodule

// File: rtl/baud_gen_checker.sv
module baud_gen_checker
  import baud_gen_pkg::*;
#(
  parameter int unsigned RW = RELOAD_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_o,
  input logic             running_o,
  input logic             reload_we_i,
  input logic [RW-1:0]    reload_q,
  input logic [PRE_W-1:0] pre_cnt,
  input logic [RW-1:0]    cnt_val
);
  assert_tick_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);

  assert_no_tick_stopped_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !running_o |-> !tick_o);

  assert_stop_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !running_o |=> pre_cnt == '0);

  assert_reload_locked_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reload_we_i && running_o) |=> $stable(reload_q));

  assert_presc_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_cnt <= PRE_W'(2));

  assert_count_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running_o |-> cnt_val <= reload_q);
endmodule

bind baud_tick_gen baud_gen_checker #(.RW(RW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_o(tick_o), .running_o(running_o),
  .reload_we_i(reload_we_i), .reload_q(reload_q), .pre_cnt(pre_cnt),
  .cnt_val(cnt_val)
);

// File: tb/baud_tick_gen_bench.sv
`timescale 1ns/1ps
module baud_tick_gen_bench;
  localparam int CLK_NS = 10;
  localparam int LIM    = 30000;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        ctrl_we = 0;
  logic [15:0] ctrl_wdata = '0;
  logic        reload_we = 0;
  logic [12:0] reload_wdata = '0;
  logic        tick, running;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  baud_tick_gen u_baud_tick_gen (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wdata),
    .reload_we_i(reload_we), .reload_wdata_i(reload_wdata),
    .tick_o(tick), .running_o(running)
  );

  function automatic int exp_period(int presel, int r);
    return (presel ? 3 : 2) * (r + 1);
  endfunction

  function automatic int baud_reload(longint f, longint baud);
    return int'((f / (16 * baud)) / 2 - 1);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ctrl_wr(bit run, bit presel, bit frac);
    @(negedge clk);
    ctrl_we = 1;
    ctrl_wdata = '0;
    ctrl_wdata[15] = run;
    ctrl_wdata[9]  = frac;
    ctrl_wdata[8]  = presel;
    @(negedge clk);
    ctrl_we = 0;
  endtask

  task automatic reload_wr(int v);
    @(negedge clk);
    reload_we = 1;
    reload_wdata = 13'(v);
    @(negedge clk);
    reload_we = 0;
  endtask

  task automatic both_wr(int v, bit presel);
    @(negedge clk);
    reload_we = 1;
    reload_wdata = 13'(v);
    ctrl_we = 1;
    ctrl_wdata = '0;
    ctrl_wdata[15] = 1;
    ctrl_wdata[8] = presel;
    @(negedge clk);
    reload_we = 0;
    ctrl_we = 0;
  endtask

  // caller sits at the negedge after the capturing edge (k = 0)
  task automatic wait_tick(output int k);
    k = 0;
    while (!tick && k < LIM) begin
      @(negedge clk);
      k++;
    end
  endtask

  // caller sits at a tick negedge
  task automatic next_period(output int k);
    @(negedge clk);
    k = 1;
    while (!tick && k < LIM) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic run_case(int r, bit presel, bit frac, string tag);
    int k;
    ctrl_wr(0, presel, frac);
    reload_wr(r);
    ctrl_wr(1, presel, frac);
    wait_tick(k);
    check(k == exp_period(presel, r) - 1, {tag, " R3 first tick"}, k, exp_period(presel, r) - 1);
    next_period(k);
    check(k == exp_period(presel, r), {tag, " R2 period"}, k, exp_period(presel, r));
  endtask

  initial begin
    #(CLK_NS * 190000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int k, cnt, r, p;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(tick == 0, "R1 tick at reset", int'(tick), 0);
    check(running == 0, "R1 running at reset", int'(running), 0);
    rst_n = 1;
    @(negedge clk);
    // R1 default reload 0 and /2: start without programming
    ctrl_wr(1, 0, 0);
    check(running == 1, "R5 running after start", int'(running), 1);
    wait_tick(k);
    check(k == 1, "R1 default first tick", k, 1);
    @(negedge clk);
    check(tick == 0, "R4 single-cycle tick", int'(tick), 0);
    @(negedge clk);
    check(tick == 1, "R1 default period 2", int'(tick), 1);

    // R5 stop: no ticks, running low
    ctrl_wr(0, 0, 0);
    check(running == 0, "R5 running after stop", int'(running), 0);
    cnt = 0;
    for (int i = 0; i < 60; i++) begin
      if (tick) cnt++;
      @(negedge clk);
    end
    check(cnt == 0, "R5 ticks while stopped", cnt, 0);

    // random mix, R2 and R3
    for (int i = 0; i < 8; i++) begin
      r = int'($urandom % 40);
      p = int'($urandom % 2);
      run_case(r, p[0], 0, "rand");
    end

    // R2 /3 directed
    run_case(4, 1, 0, "div3");

    // R8 fractional bit inert
    run_case(3, 1, 1, "R8 frac on");
    run_case(6, 0, 1, "R8 frac on");

    // R6 reload write while running ignored
    run_case(5, 0, 0, "R6 base");
    reload_wr(20);
    wait_tick(k);
    next_period(k);
    check(k == 12, "R6 period after ignored write", k, 12);
    ctrl_wr(0, 0, 0);
    ctrl_wr(1, 0, 0);
    wait_tick(k);
    check(k == 11, "R6 restart keeps held value", k, 11);

    // R7 reload in same cycle as run
    ctrl_wr(0, 0, 0);
    both_wr(7, 1);
    wait_tick(k);
    check(k == 23, "R7 same-cycle reload first tick", k, 23);
    next_period(k);
    check(k == 24, "R7 same-cycle reload period", k, 24);

    // R9 baud formula: 36.864 MHz, 115200 baud -> period 20
    run_case(baud_reload(64'd36864000, 64'd115200), 0, 0, "R9 baud");
    check(baud_reload(64'd36864000, 64'd115200) == 9, "R9 reload value",
          baud_reload(64'd36864000, 64'd115200), 9);

    // R7 13-bit max reload
    run_case(8191, 1, 0, "R7 max");

    // R4 at max: tick drops next cycle
    @(negedge clk);
    check(tick == 0, "R4 tick width at max", int'(tick), 0);
    ctrl_wr(0, 0, 0);
    check(tick == 0, "R5 no tick after stop", int'(tick), 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule